// File: doc/BRIEF.md
# Auto-Increment Register Bank for a Four-Channel Sampler

This block holds the control, limit and result bytes of a four-channel, 12-bit sampling converter behind a byte-wide transaction port. A host first loads a pointer byte. The low seven bits of that byte select a register. The top bit chooses whether the selected address steps forward after each read. After that, single-cycle strobes either write one byte to the selected register or read one byte back. Read data appears one clock after the strobe.

Conversion results do not come from the host. A sideband load port places each 12-bit sample into its channel's upper/lower byte pair, left-justified, so that a two-byte incrementing read returns the sample big-endian. Only the control, limit and configuration registers accept host writes. A magic byte written to the last register clears the whole bank. A parameter sets what the increment does at the top of the map: it either holds there or wraps back to address zero.

Top module: `arf_regbank`

## Requirements
- R1: After the hardware reset input (`rst_n` low), every register from 0x00 to 0x16 reads 0x00, `rd_valid` is low, and the pointer selects 0x00 with increment off.
- R2: A pointer load takes bits 6:0 of `ptr_byte` as the address and bit 7 as the increment flag. A read strobe returns the selected byte on `rd_byte` with `rd_valid` high in the following cycle, and `rd_valid` is low in any cycle that does not follow a read strobe.
- R3: With the increment flag set, the address advances by one after each read. With it clear, repeated reads return the same register.
- R4: Host writes are stored at 0x00, 0x01 and 0x0A through 0x15, and are read back unchanged.
- R5: Host writes to the result bytes 0x02 through 0x09, and to any address above 0x16, leave every register unchanged.
- R6: Writing 0xAA to 0x16 clears every register, the results included, to 0x00. Writing any other value there changes nothing. Address 0x16 always reads 0x00.
- R7: A sideband load of sample S on channel k (0 to 3) sets register 0x02+2k to S[11:4] and register 0x03+2k to {S[3:0], 4'b0000}.
- R8: Two incrementing reads that start at 0x02+2k return the upper byte and then the lower byte, so {first, second} >> 4 equals the sample.
- R9: Reads from any address above 0x16 return 0x00, and an incrementing read there leaves the address where it is.
- R10: An incrementing read at 0x16 leaves the address at 0x16 when `WRAP_AT_END` is 0, and moves it to 0x00 when `WRAP_AT_END` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ptr_load | input | 1 | Load the pointer from `ptr_byte`; takes priority over the strobes in the same cycle |
| ptr_byte | input | 8 | Bit 7 is the increment flag, bits 6:0 are the register address |
| wr_strobe | input | 1 | Write `wr_byte` to the selected register |
| wr_byte | input | 8 | Write data |
| rd_strobe | input | 1 | Read the selected register |
| rd_byte | output | 8 | Read data, valid the cycle after a read strobe |
| rd_valid | output | 1 | High for one cycle after each read strobe |
| smp_load | input | 1 | Sideband sample load |
| smp_chan | input | 2 | Channel index for the sample load |
| smp_value | input | 12 | Sample value |

## Verification
The assertions assume that `ptr_load`, `wr_strobe` and `rd_strobe` are never high in the same cycle. The design gives the pointer load priority in that case, and the properties do not cover it. The address-stepping and read-value properties also assume that the address only changes through a pointer load or an incrementing read. The bench keeps within both assumptions. Each transaction task raises exactly one strobe for one cycle, and every input changes on the falling clock edge. The sideband load is driven only while no host strobe is active.

// File: rtl/arf_pkg.sv
package arf_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SOFT_RESET_KEY = 8'hAA;

    // pointer state: increment flag and current address
    typedef struct packed {
        logic              inc;
        logic [ADDR_W-1:0] addr;
    } arf_ptr_t;

    // registered read port state
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } arf_rd_t;

    // map: 2 control, 2*N result, 2*N limit, 5 configuration/reset
    function automatic int arf_last_addr(input int nch);
        return 2 + 4 * nch + 4;
    endfunction
endpackage

// File: rtl/arf_pointer.sv
module arf_pointer
    import arf_pkg::*;
#(
    parameter int LAST_ADDR   = 22,
    parameter bit WRAP_AT_END = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [7:0]        ptr_byte,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              inc_en
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    arf_ptr_t ptr_d, ptr_q;
    logic [ADDR_W-1:0] end_next;

    generate
        if (WRAP_AT_END) begin : g_wrap
            assign end_next = '0;
        end else begin : g_sat
            assign end_next = LAST;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_load) begin
            ptr_d.inc  = ptr_byte[7];
            ptr_d.addr = ptr_byte[ADDR_W-1:0];
        end else if (rd_step && ptr_q.inc) begin
            if (ptr_q.addr < LAST) begin
                ptr_d.addr = ptr_q.addr + ADDR_W'(1);
            end else if (ptr_q.addr == LAST) begin
                ptr_d.addr = end_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign cur_addr = ptr_q.addr;
    assign inc_en   = ptr_q.inc;
endmodule

// File: rtl/arf_storage.sv
module arf_storage
    import arf_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 12,
    parameter int CH_W     = 2,
    parameter int NREG     = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_byte,
    input  logic                         smp_load,
    input  logic [CH_W-1:0]              smp_chan,
    input  logic [SAMPLE_W-1:0]          smp_value,
    output logic [NREG-1:0][BYTE_W-1:0]  regs
);
    localparam int RES_BASE = 2;
    localparam int LIM_BASE = RES_BASE + 2 * NUM_CH;
    localparam int LAST     = NREG - 1;
    localparam int PAD      = 16 - SAMPLE_W;

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] bank;
    } store_t;

    store_t st_d, st_q;
    logic [NREG-1:0] wr_hit;
    logic [15:0]     smp_just;
    logic            soft_rst;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_dec
            localparam bit WR_OK = (i < RES_BASE) || ((i >= LIM_BASE) && (i < LAST));
            if (WR_OK) begin : g_rw
                assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
            end else begin : g_ro
                assign wr_hit[i] = 1'b0;
            end
        end
    endgenerate

    assign smp_just = 16'(smp_value) << PAD;
    assign soft_rst = wr_en && (wr_addr == ADDR_W'(LAST)) && (wr_byte == SOFT_RESET_KEY);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_hit[i]) begin
                st_d.bank[i] = wr_byte;
            end
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (smp_load && (smp_chan == CH_W'(k))) begin
                st_d.bank[RES_BASE + 2 * k]     = smp_just[15:8];
                st_d.bank[RES_BASE + 2 * k + 1] = smp_just[7:0];
            end
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.bank;
endmodule

// File: rtl/arf_readport.sv
module arf_readport
    import arf_pkg::*;
#(
    parameter int NREG = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NREG-1:0][BYTE_W-1:0]  regs,
    output logic [BYTE_W-1:0]            rd_byte,
    output logic                         rd_valid
);
    arf_rd_t rd_d, rd_q;
    logic [BYTE_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                sel = regs[i];
            end
        end
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            rd_d.data = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_byte  = rd_q.data;
    assign rd_valid = rd_q.valid;
endmodule

// File: rtl/arf_regbank.sv
module arf_regbank
    import arf_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SAMPLE_W    = 12,
    parameter bit WRAP_AT_END = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptr_load,
    input  logic [7:0]                    ptr_byte,
    input  logic                          wr_strobe,
    input  logic [7:0]                    wr_byte,
    input  logic                          rd_strobe,
    output logic [7:0]                    rd_byte,
    output logic                          rd_valid,
    input  logic                          smp_load,
    input  logic [$clog2(NUM_CH)-1:0]     smp_chan,
    input  logic [SAMPLE_W-1:0]           smp_value
);
    localparam int LAST_ADDR = arf_last_addr(NUM_CH);
    localparam int NREG      = LAST_ADDR + 1;
    localparam int CH_W      = $clog2(NUM_CH);

    logic                        rd_go;
    logic                        wr_go;
    logic [ADDR_W-1:0]           cur_addr;
    logic                        inc_en;
    logic [NREG-1:0][BYTE_W-1:0] regs;

    assign rd_go = rd_strobe && !ptr_load;
    assign wr_go = wr_strobe && !ptr_load;

    arf_pointer #(
        .LAST_ADDR  (LAST_ADDR),
        .WRAP_AT_END(WRAP_AT_END)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_load(ptr_load),
        .ptr_byte(ptr_byte),
        .rd_step (rd_go),
        .cur_addr(cur_addr),
        .inc_en  (inc_en)
    );

    arf_storage #(
        .NUM_CH  (NUM_CH),
        .SAMPLE_W(SAMPLE_W),
        .CH_W    (CH_W),
        .NREG    (NREG)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .wr_addr  (cur_addr),
        .wr_byte  (wr_byte),
        .smp_load (smp_load),
        .smp_chan (smp_chan),
        .smp_value(smp_value),
        .regs     (regs)
    );

    arf_readport #(
        .NREG(NREG)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_go),
        .rd_addr (cur_addr),
        .regs    (regs),
        .rd_byte (rd_byte),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/arf_regbank_chk.sv
module arf_regbank_chk #(
    parameter int LAST_ADDR = 22,
    parameter int SAMPLE_W  = 12,
    parameter int RES_LO    = 2,
    parameter int RES_HI    = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ptr_load,
    input logic       rd_strobe,
    input logic [6:0] cur_addr,
    input logic       inc_en,
    input logic [7:0] rd_byte,
    input logic       rd_valid
);
    localparam logic [6:0] LAST    = 7'(LAST_ADDR);
    localparam logic [7:0] LO_MASK = 8'((1 << (16 - SAMPLE_W)) - 1);

    logic rd_go;
    assign rd_go = rd_strobe && !ptr_load;

    // R2: valid strictly follows a read strobe
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> rd_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !rd_valid);

    // R3: fixed address without increment, one step with it
    a_r3_hold_without_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !inc_en) |=> $stable(cur_addr));
    a_r3_step_with_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && inc_en && (cur_addr < LAST)) |=> (cur_addr == $past(cur_addr) + 7'd1));

    // R6: reset register reads zero
    a_r6_reset_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (cur_addr == LAST)) |=> (rd_byte == 8'h00));

    // R7: low padding bits of a lower result byte are zero
    a_r7_lower_padding_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (cur_addr >= 7'(RES_LO)) && (cur_addr <= 7'(RES_HI)) && cur_addr[0])
        |=> ((rd_byte & LO_MASK) == 8'h00));

    // R9: undefined addresses read zero and are never stepped
    a_r9_undefined_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (cur_addr > LAST)) |=> (rd_byte == 8'h00));
    a_r9_undefined_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (cur_addr > LAST)) |=> $stable(cur_addr));

    // R10: stepping at the top stays in the map
    a_r10_top_stays_in_map: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && inc_en && (cur_addr == LAST)) |=> ((cur_addr == LAST) || (cur_addr == 7'd0)));
endmodule

bind arf_regbank arf_regbank_chk #(
    .LAST_ADDR(LAST_ADDR),
    .SAMPLE_W (SAMPLE_W),
    .RES_LO   (2),
    .RES_HI   (1 + 2 * NUM_CH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .rd_strobe(rd_strobe),
    .cur_addr (cur_addr),
    .inc_en   (inc_en),
    .rd_byte  (rd_byte),
    .rd_valid (rd_valid)
);

// File: tb/test_arf_regbank.sv
module test_arf_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_load = 1'b0;
    logic [7:0]  ptr_byte = '0;
    logic        wr_strobe = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        rd_strobe = 1'b0;
    logic        smp_load = 1'b0;
    logic [1:0]  smp_chan = '0;
    logic [11:0] smp_value = '0;
    logic [7:0]  rd_byte, rd_byte_w;
    logic        rd_valid, rd_valid_w;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] model [23];

    always #5 clk = ~clk;

    arf_regbank i_arf_regbank (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_byte(ptr_byte),
        .wr_strobe(wr_strobe), .wr_byte(wr_byte), .rd_strobe(rd_strobe),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .smp_load(smp_load),
        .smp_chan(smp_chan), .smp_value(smp_value)
    );

    arf_regbank #(.WRAP_AT_END(1'b1)) i_arf_regbank_wrap (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_byte(ptr_byte),
        .wr_strobe(wr_strobe), .wr_byte(wr_byte), .rd_strobe(rd_strobe),
        .rd_byte(rd_byte_w), .rd_valid(rd_valid_w), .smp_load(smp_load),
        .smp_chan(smp_chan), .smp_value(smp_value)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [7:0] b);
        @(negedge clk); ptr_load = 1'b1; ptr_byte = b;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_strobe = 1'b1; wr_byte = b;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        b = rd_byte;
    endtask

    task automatic load_smp(input logic [1:0] ch, input logic [11:0] v);
        @(negedge clk); smp_load = 1'b1; smp_chan = ch; smp_value = v;
        @(negedge clk); smp_load = 1'b0;
        model[2 + 2 * ch]     = v[11:4];
        model[2 + 2 * ch + 1] = {v[3:0], 4'h0};
    endtask

    // write through the pointer, update model per R4/R5/R6
    task automatic wr_at(input logic [6:0] a, input logic [7:0] b);
        set_ptr({1'b0, a});
        wr(b);
        if (a == 7'h16 && b == 8'hAA) begin
            for (int i = 0; i < 23; i++) model[i] = 8'h00;
        end else if (a <= 7'h01 || (a >= 7'h0A && a <= 7'h15)) begin
            model[a] = b;
        end
    endtask

    task automatic read_all(input string req);
        logic [7:0] v;
        set_ptr(8'h80);
        for (int i = 0; i < 23; i++) begin
            rd(v);
            check(req, {8'h0, v}, {8'h0, model[i]});
        end
    endtask

    task automatic t_reset;
        check("R1 rd_valid after reset", {15'h0, rd_valid}, 16'h0);
        for (int i = 0; i < 23; i++) model[i] = 8'h00;
        read_all("R1 reset value");
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        wr_at(7'h0A, 8'h5A);
        wr_at(7'h0B, 8'hC3);
        set_ptr(8'h0A);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        check("R2 rd_valid one cycle after strobe", {15'h0, rd_valid}, 16'h1);
        check("R2 read data", {8'h0, rd_byte}, 16'h005A);
        @(negedge clk);
        check("R2 rd_valid drops", {15'h0, rd_valid}, 16'h0);
        rd(v); check("R3 no increment holds address", {8'h0, v}, 16'h005A);
        set_ptr(8'h8A);
        rd(v); check("R3 increment first", {8'h0, v}, 16'h005A);
        rd(v); check("R3 increment second", {8'h0, v}, 16'h00C3);
    endtask

    task automatic t_writes;
        for (int a = 0; a < 22; a++) begin
            wr_at(7'(a), 8'(8'h30 + a));
        end
        read_all("R4 R5 writable map");
    endtask

    task automatic t_samples;
        logic [7:0] hi, lo;
        logic [11:0] vals [4];
        vals[0] = 12'hABC; vals[1] = 12'h123; vals[2] = 12'hFFF; vals[3] = 12'h001;
        for (int k = 0; k < 4; k++) begin
            load_smp(2'(k), vals[k]);
        end
        for (int k = 0; k < 4; k++) begin
            set_ptr(8'(8'h82 + 2 * k));
            rd(hi); rd(lo);
            check("R7 upper byte", {8'h0, hi}, {8'h0, vals[k][11:4]});
            check("R7 lower byte", {8'h0, lo}, {8'h0, vals[k][3:0], 4'h0});
            check("R8 big-endian burst", {hi, lo} >> 4, {4'h0, vals[k]});
        end
        wr_at(7'h04, 8'h55);
        wr_at(7'h09, 8'h0F);
        read_all("R5 result writes ignored");
    endtask

    task automatic t_undefined;
        logic [7:0] v;
        wr_at(7'h20, 8'h77);
        read_all("R5 undefined write ignored");
        set_ptr(8'hA0);
        rd(v); check("R9 undefined read zero", {8'h0, v}, 16'h0);
        rd(v); check("R9 undefined read zero again", {8'h0, v}, 16'h0);
        set_ptr(8'h7F);
        rd(v); check("R9 address 0x7F reads zero", {8'h0, v}, 16'h0);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        wr_at(7'h00, 8'h11);
        wr_at(7'h01, 8'h22);
        wr_at(7'h15, 8'h44);
        set_ptr(8'h95);
        rd(v); check("R10 start 0x15", {8'h0, v, rd_byte_w}, 16'h4444);
        rd(v); check("R10 at 0x16", {8'h0, v, rd_byte_w}, 16'h0000);
        rd(v); check("R10 saturate vs wrap step1", {v, rd_byte_w}, 16'h0011);
        rd(v); check("R10 saturate vs wrap step2", {v, rd_byte_w}, 16'h0022);
    endtask

    task automatic t_softreset;
        logic [7:0] v;
        wr_at(7'h16, 8'h55);
        read_all("R6 non-key write has no effect");
        wr_at(7'h16, 8'hAB);
        set_ptr(8'h16);
        rd(v); check("R6 reset register reads zero", {8'h0, v}, 16'h0);
        check("R6 bank intact before key", {8'h0, model[2]}, 16'h00AB);
        wr_at(7'h16, 8'hAA);
        read_all("R6 key clears bank");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_writes();
        t_samples();
        t_undefined();
        t_wrap();
        t_softreset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule